// File: doc/BRIEF.md
# ATA Multiword DMA Host Sequencer

This block is the host-side timing engine for multiword DMA transfers on a 16-bit ATA data bus. While it is enabled, it waits for the device to raise its DMA request. It then pulls the acknowledge low and moves one word per strobe cycle. Read words are latched from the bus. Write words are taken from a valid/ready stream and driven onto the bus. The burst goes on for as long as the request stays high.

All timing comes from one 32-bit configuration word that holds three cycle counts. The setup count sets the delay before each strobe. The strobe count sets how long the read or write strobe stays low. The end-of-cycle count sets the minimum spacing from one strobe assertion to the next. A count of N always means N+1 clock cycles.

A package helper turns a time in picoseconds into a count. When the time divides exactly by the clock period, the helper loads the quotient minus one. When the division leaves a remainder, it loads the quotient. This helper lets software derive the configuration word from a table of bus timings. The configuration and direction must stay unchanged while a burst is running. The direction is sampled when each burst starts.

Top module: `mwdma_seq`

## Requirements
- R1: The configuration word is decoded as follows: setup count in bits [3:0], strobe count in bits [11:4], end-of-cycle count in bits [19:12]. Bits [31:20] are ignored. A count N lasts N+1 clock cycles.
- R2: After reset, and whenever the block is idle, the outputs are: acknowledge high, both strobes high, bus output enable low, read-valid low, write-ready low.
- R3: When the request is seen with the block enabled, the acknowledge goes low. The first strobe goes low exactly setup+1 cycles after the acknowledge falls. A strobe is never low while the acknowledge is high.
- R4: Each strobe stays low for exactly strobe+1 cycles. The read strobe and the write strobe are never low together.
- R5: Within a burst where data is always available, consecutive strobe falls are max(end-of-cycle+1, strobe+2) cycles apart.
- R6: On a write (direction input 1), the bus output enable is high exactly while the write strobe is low. The bus holds one stream word, unchanged, for the whole strobe. Words appear in the order the stream delivered them. On a read, the output enable stays low.
- R7: On a read (direction input 0), the bus value is captured at the clock edge that releases the read strobe. The captured word appears on rd_data together with a one-cycle rd_valid pulse in the first cycle the strobe is high again.
- R8: If the request is low when a word's cycle completes, the acknowledge rises max(1, end-of-cycle − strobe) + setup + 1 cycles after that word's strobe is released.
- R9: On a write, if no stream word is valid when a strobe is due, the strobe is held off while the acknowledge stays low. The strobe falls one cycle after the word becomes valid.
- R10: Clearing the enable during a strobe lets that word finish at full width. The burst then ends with the R8 tail timing. No new burst starts while the enable is low, even with the request high.
- R11: Both chip-select outputs stay high at all times.
- R12: The package helper converts 50 ns, 215 ns and 265 ns at a 10 ns clock into 4, 21 and 26, which pack to 0x0001A154. An exact multiple such as 40 ns gives 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Allows new bursts and continuation of a running burst |
| wr_dir | input | 1 | 1 = write to device, 0 = read; sampled at burst start |
| timing_cfg | input | 32 | Packed setup / strobe / end-of-cycle counts |
| dmarq | input | 1 | Device DMA request, active high |
| dmack_n | output | 1 | DMA acknowledge, active low |
| cs0_n | output | 1 | Chip select 0, held high |
| cs1_n | output | 1 | Chip select 1, held high |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| dd_out | output | 16 | Data driven to the bus |
| dd_oe | output | 1 | Bus output enable |
| dd_in | input | 16 | Data sampled from the bus |
| wr_data | input | 16 | Write word stream data |
| wr_valid | input | 1 | Write word stream valid |
| wr_ready | output | 1 | Write word accepted on this cycle when valid |
| rd_data | output | 16 | Last word read |
| rd_valid | output | 1 | One-cycle pulse marking a new rd_data |

## Verification
The bench measures the distance in cycles between edges on the acknowledge and the strobes. An off-by-one in how a count maps to cycles therefore shows up as a wrong setup delay, a wrong strobe width or a wrong tail. It runs one configuration where the end-of-cycle count is below the strobe count. A design that left out the minimum one-cycle recovery, or that took the end-of-cycle count as the only source of spacing, would show a wrong strobe spacing there. Write holds with no stream data check that the strobe waits and does not drive stale data. Clearing the enable during a strobe checks that the word is neither cut short nor followed by an extra word.

// File: rtl/mwdma_pkg.sv
package mwdma_pkg;

    localparam int SETUP_W = 4;
    localparam int STRB_W  = 8;
    localparam int EOC_W   = 8;
    localparam int CFG_W   = 32;
    localparam int CNT_W   = STRB_W + 1;

    typedef struct packed {
        logic [EOC_W-1:0]   eoc;
        logic [STRB_W-1:0]  strb;
        logic [SETUP_W-1:0] setup;
    } mw_timing_t;

    localparam int TIM_W = $bits(mw_timing_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WAITW,
        ST_STRB,
        ST_RECOV,
        ST_TAIL
    } mw_state_e;

    // Remainder keeps the quotient, exact division drops one.
    function automatic int unsigned time_to_count(int unsigned t_ps, int unsigned clk_ps);
        int unsigned q;
        q = t_ps / clk_ps;
        if ((t_ps % clk_ps) == 0 && q != 0)
            q = q - 1;
        return q;
    endfunction

    function automatic logic [CFG_W-1:0] pack_timing(int unsigned setup,
                                                      int unsigned strb,
                                                      int unsigned eoc);
        mw_timing_t t;
        t.setup = SETUP_W'(setup);
        t.strb  = STRB_W'(strb);
        t.eoc   = EOC_W'(eoc);
        return CFG_W'(t);
    endfunction

endpackage

// File: rtl/mwdma_cfg_unpack.sv
module mwdma_cfg_unpack
    import mwdma_pkg::*;
(
    input  logic [CFG_W-1:0] cfg_word,
    output mw_timing_t       tim
);
    logic [CFG_W-TIM_W-1:0] unused_hi;

    assign tim       = cfg_word[TIM_W-1:0];
    assign unused_hi = cfg_word[CFG_W-1:TIM_W];
endmodule

// File: rtl/mwdma_timer.sv
module mwdma_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAXV = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (cnt != MAXV)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mwdma_ctrl.sv
module mwdma_ctrl
    import mwdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             wr_dir,
    input  logic             dmarq,
    input  logic             wr_valid,
    input  mw_timing_t       tim,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clr,
    output mw_state_e        state,
    output logic             is_wr,
    output logic             take,
    output logic             cap
);
    mw_state_e nxt;
    logic      go;
    logic      word_ok;
    logic      setup_done;
    logic      strb_done;
    logic      eoc_done;

    assign go         = en && dmarq;
    assign word_ok    = !is_wr || wr_valid;
    assign setup_done = cnt >= CNT_W'(tim.setup);
    assign strb_done  = cnt >= CNT_W'(tim.strb);
    assign eoc_done   = cnt >= CNT_W'(tim.eoc);

    always_comb begin
        nxt     = state;
        cnt_clr = 1'b0;
        take    = 1'b0;
        cap     = 1'b0;
        unique case (state)
            ST_IDLE: if (go) begin
                nxt     = ST_SETUP;
                cnt_clr = 1'b1;
            end
            ST_SETUP: begin
                if (!go) begin
                    nxt     = ST_TAIL;
                    cnt_clr = 1'b1;
                end else if (setup_done) begin
                    take = 1'b1;
                    if (word_ok) begin
                        nxt     = ST_STRB;
                        cnt_clr = 1'b1;
                    end else begin
                        nxt = ST_WAITW;
                    end
                end
            end
            ST_WAITW: begin
                if (!go) begin
                    nxt     = ST_TAIL;
                    cnt_clr = 1'b1;
                end else begin
                    take = 1'b1;
                    if (word_ok) begin
                        nxt     = ST_STRB;
                        cnt_clr = 1'b1;
                    end
                end
            end
            ST_STRB: if (strb_done) begin
                nxt = ST_RECOV;
                cap = !is_wr;
            end
            ST_RECOV: if (eoc_done) begin
                if (go) begin
                    take = 1'b1;
                    if (word_ok) begin
                        nxt     = ST_STRB;
                        cnt_clr = 1'b1;
                    end else begin
                        nxt = ST_WAITW;
                    end
                end else begin
                    nxt     = ST_TAIL;
                    cnt_clr = 1'b1;
                end
            end
            ST_TAIL: if (setup_done) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            is_wr <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && go)
                is_wr <= wr_dir;
        end
    end
endmodule

// File: rtl/mwdma_datapath.sv
module mwdma_datapath #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_wr,
    input  logic [DW-1:0] wr_data,
    input  logic          cap,
    input  logic [DW-1:0] dd_in,
    output logic [DW-1:0] dd_out,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dd_out   <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= cap;
            if (load_wr)
                dd_out <= wr_data;
            if (cap)
                rd_data <= dd_in;
        end
    end
endmodule

// File: rtl/mwdma_seq.sv
module mwdma_seq
    import mwdma_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              wr_dir,
    input  logic [CFG_W-1:0]  timing_cfg,
    input  logic              dmarq,
    output logic              dmack_n,
    output logic              cs0_n,
    output logic              cs1_n,
    output logic              dior_n,
    output logic              diow_n,
    output logic [DATA_W-1:0] dd_out,
    output logic              dd_oe,
    input  logic [DATA_W-1:0] dd_in,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    mw_timing_t       tim;
    mw_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic             cnt_clr;
    logic             is_wr;
    logic             take;
    logic             cap;
    logic             strb_on;

    mwdma_cfg_unpack u_cfg (
        .cfg_word (timing_cfg),
        .tim      (tim)
    );

    mwdma_timer #(.W(CNT_W)) u_tmr (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .cnt (cnt)
    );

    mwdma_ctrl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .wr_dir   (wr_dir),
        .dmarq    (dmarq),
        .wr_valid (wr_valid),
        .tim      (tim),
        .cnt      (cnt),
        .cnt_clr  (cnt_clr),
        .state    (state),
        .is_wr    (is_wr),
        .take     (take),
        .cap      (cap)
    );

    assign wr_ready = take && is_wr;

    mwdma_datapath #(.DW(DATA_W)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .load_wr  (wr_ready && wr_valid),
        .wr_data  (wr_data),
        .cap      (cap),
        .dd_in    (dd_in),
        .dd_out   (dd_out),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign strb_on = (state == ST_STRB);
    assign dmack_n = (state == ST_IDLE);
    assign cs0_n   = 1'b1;
    assign cs1_n   = 1'b1;
    assign diow_n  = !(strb_on && is_wr);
    assign dior_n  = !(strb_on && !is_wr);
    assign dd_oe   = strb_on && is_wr;
endmodule

// File: rtl/mwdma_seq_chk.sv
module mwdma_seq_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              dmack_n,
    input logic              cs0_n,
    input logic              cs1_n,
    input logic              dior_n,
    input logic              diow_n,
    input logic              dd_oe,
    input logic [DATA_W-1:0] dd_out,
    input logic              rd_valid
);
    AST_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
        cs0_n && cs1_n); // R11

    AST_STROBE_UNDER_ACK: assert property (@(posedge clk) disable iff (rst)
        (!dior_n || !diow_n) |-> !dmack_n); // R3

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(!dior_n && !diow_n)); // R4

    AST_OE_WITH_WRITE: assert property (@(posedge clk) disable iff (rst)
        dd_oe |-> (!diow_n && dior_n)); // R6

    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!diow_n && $past(!diow_n)) |-> $stable(dd_out)); // R6

    AST_RD_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (dior_n && $past(!dior_n))); // R7

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid); // R7
endmodule

bind mwdma_seq mwdma_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .dmack_n  (dmack_n),
    .cs0_n    (cs0_n),
    .cs1_n    (cs1_n),
    .dior_n   (dior_n),
    .diow_n   (diow_n),
    .dd_oe    (dd_oe),
    .dd_out   (dd_out),
    .rd_valid (rd_valid)
);

// File: tb/sim_mwdma_seq.sv
`timescale 1ns/1ps
module sim_mwdma_seq;
    import mwdma_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        wr_dir = 1'b0;
    logic [31:0] timing_cfg = '0;
    logic        dmarq = 1'b0;
    logic        dmack_n, cs0_n, cs1_n, dior_n, diow_n, dd_oe, wr_ready, rd_valid;
    logic [15:0] dd_out, rd_data;
    logic [15:0] dd_in = '0;
    logic [15:0] wr_data;
    logic        wr_valid;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    mwdma_seq u0 (
        .clk(clk), .rst(rst), .en(en), .wr_dir(wr_dir), .timing_cfg(timing_cfg),
        .dmarq(dmarq), .dmack_n(dmack_n), .cs0_n(cs0_n), .cs1_n(cs1_n),
        .dior_n(dior_n), .diow_n(diow_n), .dd_out(dd_out), .dd_oe(dd_oe),
        .dd_in(dd_in), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // write word producer
    logic prod_en = 1'b0;
    int   prod_idx = 0;
    int   prod_lim = 0;
    logic hs_q = 1'b0;
    assign wr_valid = prod_en && (prod_idx < prod_lim);
    assign wr_data  = 16'hA000 + 16'(prod_idx);
    always @(posedge clk) hs_q <= wr_valid && wr_ready;

    // monitor
    int cyc = 0;
    int nfall = 0, nrise = 0, nrd = 0, nwr = 0, oe_bad = 0, dir_used_r = 0, dir_used_w = 0;
    int ack_fall = -1, ack_rise = -1;
    int fall_cyc[16], rise_cyc[16], rd_cyc[16];
    logic [15:0] rd_val[16], wr_seen[16];
    logic prev_low = 1'b0, prev_ack = 1'b1;
    logic [15:0] cur_w = '0;

    always @(negedge clk) begin
        cyc++;
        if (hs_q) prod_idx++;
        if (!rst) begin
            if (!prev_low && (!dior_n || !diow_n)) begin
                if (nfall < 16) fall_cyc[nfall] = cyc;
                if (!dior_n) begin dir_used_r++; dd_in = 16'h5100 + 16'(nfall); end
                if (!diow_n) begin
                    dir_used_w++;
                    cur_w = dd_out;
                    if (nwr < 16) wr_seen[nwr] = dd_out;
                    nwr++;
                end
                nfall++;
            end
            if (prev_low && dior_n && diow_n) begin
                if (nrise < 16) rise_cyc[nrise] = cyc;
                nrise++;
            end
            if (prev_ack && !dmack_n) ack_fall = cyc;
            if (!prev_ack && dmack_n) ack_rise = cyc;
            if (dd_oe != !diow_n) oe_bad++;
            if (!diow_n && dd_out != cur_w) oe_bad++;
            if (rd_valid) begin
                if (nrd < 16) begin rd_cyc[nrd] = cyc; rd_val[nrd] = rd_data; end
                nrd++;
            end
            prev_low = !dior_n || !diow_n;
            prev_ack = dmack_n;
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clr_mon();
        nfall = 0; nrise = 0; nrd = 0; nwr = 0; oe_bad = 0;
        dir_used_r = 0; dir_used_w = 0; ack_fall = -1; ack_rise = -1;
        prod_idx = 0;
    endtask

    task automatic wait_falls(input int n);
        for (int i = 0; i < 2000 && nfall < n; i++) step();
        check(nfall >= n, "R3", "strobe never reached count", nfall, n);
    endtask

    task automatic wait_ack_rise();
        for (int i = 0; i < 2000 && ack_rise < 0; i++) step();
        check(ack_rise >= 0, "R8", "acknowledge never released", ack_rise, 0);
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // generic burst: nw words, given counts and direction
    task automatic burst(input int tm, input int td, input int te, input int nw, input bit wr);
        int sp;
        int tail;
        clr_mon();
        timing_cfg = pack_timing(tm, td, te) | 32'hFFF0_0000; // R1: upper bits ignored
        wr_dir = wr; prod_lim = nw; prod_en = wr;
        step();
        dmarq = 1'b1;
        wait_falls(nw);
        dmarq = 1'b0;
        wait_ack_rise();
        prod_en = 1'b0;
        step(); step();
        sp   = imax(te + 1, td + 2);
        tail = imax(1, te - td) + tm + 1;
        check(nfall == nw, "R5", "words in burst", nfall, nw);
        check(fall_cyc[0] - ack_fall == tm + 1, "R3", "setup delay", fall_cyc[0] - ack_fall, tm + 1);
        for (int i = 0; i < nw; i++)
            check(rise_cyc[i] - fall_cyc[i] == td + 1, "R4", "strobe width", rise_cyc[i] - fall_cyc[i], td + 1);
        for (int i = 1; i < nw; i++)
            check(fall_cyc[i] - fall_cyc[i-1] == sp, "R5", "strobe spacing", fall_cyc[i] - fall_cyc[i-1], sp);
        check(ack_rise - rise_cyc[nw-1] == tail, "R8", "tail to ack release", ack_rise - rise_cyc[nw-1], tail);
        check(oe_bad == 0, "R6", "output enable / data mismatches", oe_bad, 0);
        if (wr) begin
            check(dir_used_r == 0, "R6", "read strobe during write", dir_used_r, 0);
            for (int i = 0; i < nw; i++)
                check(wr_seen[i] == 16'hA000 + 16'(i), "R6", "bus word", wr_seen[i], 16'hA000 + i);
        end else begin
            check(dir_used_w == 0, "R7", "write strobe during read", dir_used_w, 0);
            check(nrd == nw, "R7", "read pulses", nrd, nw);
            for (int i = 0; i < nw; i++) begin
                check(rd_val[i] == 16'h5100 + 16'(i), "R7", "read word", rd_val[i], 16'h5100 + i);
                check(rd_cyc[i] == rise_cyc[i], "R7", "read pulse cycle", rd_cyc[i], rise_cyc[i]);
            end
        end
        check(dmack_n && dior_n && diow_n && !dd_oe, "R2", "idle after burst", {dmack_n, dior_n, diow_n, dd_oe}, 4'b1110);
    endtask

    task automatic t_reset();
        check(dmack_n && dior_n && diow_n && !dd_oe && !rd_valid && !wr_ready, "R2",
              "reset outputs", {dmack_n, dior_n, diow_n, dd_oe, rd_valid, wr_ready}, 6'b111000);
        check(cs0_n && cs1_n, "R11", "chip selects", {cs0_n, cs1_n}, 2'b11);
    endtask

    task automatic t_convert();
        int a, b, c;
        a = time_to_count(50000, 10000);
        b = time_to_count(215000, 10000);
        c = time_to_count(265000, 10000);
        check(a == 4, "R12", "setup count", a, 4);
        check(b == 21, "R12", "strobe count", b, 21);
        check(c == 26, "R12", "eoc count", c, 26);
        check(pack_timing(a, b, c) == 32'h0001A154, "R12", "packed word", pack_timing(a, b, c), 32'h0001A154);
        check(time_to_count(40000, 10000) == 3, "R12", "exact division", time_to_count(40000, 10000), 3);
    endtask

    task automatic t_holdoff();
        int c0;
        clr_mon();
        timing_cfg = pack_timing(1, 2, 3);
        wr_dir = 1'b1; prod_lim = 1; prod_en = 1'b0;
        step();
        dmarq = 1'b1;
        for (int i = 0; i < 12; i++) step();
        check(nfall == 0, "R9", "strobe without data", nfall, 0);
        check(!dmack_n, "R9", "ack held during hold-off", dmack_n, 0);
        check(!dd_oe, "R9", "bus released during hold-off", dd_oe, 0);
        prod_en = 1'b1; c0 = cyc;
        wait_falls(1);
        dmarq = 1'b0;
        check(fall_cyc[0] == c0 + 1, "R9", "strobe after data valid", fall_cyc[0], c0 + 1);
        wait_ack_rise();
        prod_en = 1'b0;
        check(wr_seen[0] == 16'hA000, "R9", "held word", wr_seen[0], 16'hA000);
        step(); step();
    endtask

    task automatic t_disable();
        int tail;
        clr_mon();
        timing_cfg = pack_timing(1, 3, 5);
        wr_dir = 1'b0;
        step();
        dmarq = 1'b1;
        wait_falls(1);
        en = 1'b0;
        wait_ack_rise();
        tail = imax(1, 5 - 3) + 1 + 1;
        check(rise_cyc[0] - fall_cyc[0] == 4, "R10", "word finished at full width", rise_cyc[0] - fall_cyc[0], 4);
        check(ack_rise - rise_cyc[0] == tail, "R10", "tail after disable", ack_rise - rise_cyc[0], tail);
        for (int i = 0; i < 15; i++) step();
        check(nfall == 1, "R10", "words while disabled", nfall, 1);
        check(dmack_n, "R10", "ack while disabled", dmack_n, 1);
        dmarq = 1'b0;
        en = 1'b1;
        step();
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        t_reset();
        t_convert();
        en = 1'b1;
        burst(1, 2, 6, 3, 1'b1);                 // R1 R5 write, eoc dominates
        burst(0, 3, 1, 2, 1'b1);                 // R5 eoc below strobe
        burst(4, 21, 26, 2, 1'b0);               // R1 read with the 100 MHz mode-0 word
        t_holdoff();
        t_disable();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule